// File: doc/BRIEF.md
# Writeback Credit Issue Throttle

This block sits beside the issue scheduler of an out-of-order core and keeps count of instructions that have issued but not yet written back. The writeback buffer holds `WB_WIDTH` lanes per cycle slot for `WB_DEPTH` cycle slots, so its capacity is the product of the two. Each issue takes one credit. Each credit comes back through one of three paths: a normal writeback, an instruction found squashed at execute, or a memory completion that returns for a squashed load. Once every credit is in use, issue stops until a credit returns.

Issue requests arrive on several ordered ports. The throttle grants them in port order while credits remain, and stops granting for the rest of the cycle once the buffer is full. Finishing instructions ask for a writeback slot on their own ordered ports. The allocator places each one in the lowest free lane of the nearest cycle slot, moving on to the next cycle slot when all lanes of a slot are taken. The occupancy map moves one cycle slot closer each clock. Every event carries a sequence number. An optional tracker uses these numbers to flag credit returns that name no outstanding instruction.

Top module: `wb_credit_throttle`

## Requirements
- R1: After reset the outstanding count is 0, `issue_en` is 1, all three error flags are 0, and no writeback slot is occupied, so a lone slot request on port 0 is given cycle 0, lane 0.
- R2: Capacity is `WB_WIDTH*WB_DEPTH` (6 with defaults). `outstanding` never exceeds capacity, and `issue_en` is 1 exactly when `outstanding` is below capacity.
- R3: In one cycle, issue port i (port 0 first) is granted when it requests and `outstanding` plus the grants to lower ports is below capacity. An issue request while the buffer is full is denied and leaves the count unchanged.
- R4: Each issue grant adds one to the count. Each asserted return (`wb_done`, `exe_squash`, `mem_squash`) subtracts one. A return that takes the count down from capacity raises `issue_en` again at the next clock.
- R5: Grants and returns in the same cycle are netted. When they are equal the count does not change.
- R6: A net decrement below zero leaves the count at 0 and sets `underflow_err`. The flag stays set until reset.
- R7: Slot ports are served in port order. Each takes the lowest free linear position `cycle*WB_WIDTH + lane`: all lanes of a cycle slot are scanned before the next slot. `fin_cycle` and `fin_lane` give the position in binary and are valid while `fin_ok` is 1.
- R8: At every clock the occupancy moves down one cycle slot. A slot granted at cycle c is occupied at cycle c-1 one clock later, and a cycle-0 grant is released.
- R9: A slot request with no free position below capacity gets `fin_ok`=0 and sets `slot_err` at the next clock. The flag stays set until reset.
- R10: With `TRACK_TAGS`=1, a return whose sequence number matches no outstanding granted issue sets the sticky `tag_err` at the next clock. Returns that match never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_req | input | ISSUE_PORTS | Issue attempt per port, port 0 first |
| issue_seq | input | ISSUE_PORTS*SEQ_W | Sequence number per issue port |
| issue_gnt | output | ISSUE_PORTS | Issue allowed this cycle per port |
| wb_done | input | 1 | Credit return: instruction wrote back |
| wb_seq | input | SEQ_W | Sequence number of the writeback |
| exe_squash | input | 1 | Credit return: squashed at execute |
| exe_seq | input | SEQ_W | Sequence number of the squashed instruction |
| mem_squash | input | 1 | Credit return: memory completion for a squashed load |
| mem_seq | input | SEQ_W | Sequence number of the squashed load |
| fin_req | input | FIN_PORTS | Slot request per finishing instruction |
| fin_ok | output | FIN_PORTS | Slot granted per port |
| fin_cycle | output | FIN_PORTS*CYC_W | Granted cycle slot per port |
| fin_lane | output | FIN_PORTS*LANE_W | Granted lane per port |
| issue_en | output | 1 | Credits available |
| outstanding | output | CNT_W | Issued instructions not yet returned |
| underflow_err | output | 1 | Sticky: return with no credit outstanding |
| slot_err | output | 1 | Sticky: slot request found no free position |
| tag_err | output | 1 | Sticky: return with unknown sequence number |

## Verification
The assertions assume two things about the inputs. A granted issue never reuses a sequence number that is still outstanding, and no two return paths name the same sequence number in one cycle. The bench meets both by taking sequence numbers from a rising series and returning each granted instruction once, through one path. The stale-tag and underflow cases name numbers that are not outstanding, or that are still present in the tag table after the count has been driven to zero. Neither breaks either assumption.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   // Credit return paths; value is the index into the return vector.
   typedef enum logic [1:0] {
      SRC_WB  = 2'd0,
      SRC_EXE = 2'd1,
      SRC_MEM = 2'd2
   } ret_src_e;

   localparam int unsigned NUM_SRC = 3;

   function automatic int unsigned ones_src(input logic [NUM_SRC-1:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < NUM_SRC; i++) n += int'(v[i]);
      return n;
   endfunction
endpackage

// File: rtl/wbc_issue_gate.sv
module wbc_issue_gate #(
   parameter int unsigned PORTS = 2,
   parameter int unsigned CAP   = 6,
   parameter int unsigned CNT_W = 3,
   parameter int unsigned INC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [PORTS-1:0] req,
   output logic [PORTS-1:0] gnt,
   output logic [INC_W-1:0] ninc
);
   localparam logic [CNT_W:0] CAP_V = (CNT_W+1)'(CAP);

   logic [CNT_W:0] run;

   // In-order grant: each port sees the credits left after lower ports.
   always_comb begin
      run  = {1'b0, count};
      gnt  = '0;
      ninc = '0;
      for (int i = 0; i < PORTS; i++) begin
         if (req[i] && (run < CAP_V)) begin
            gnt[i] = 1'b1;
            run    = run + 1'b1;
            ninc   = ninc + 1'b1;
         end
      end
   end

   // R3: nothing is granted while every credit is taken
   a_r3_full_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, count} == CAP_V) |-> (gnt == '0));

   // R3: grants never exceed the credits left
   a_r3_grant_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(count) + $countones(gnt)) <= int'(CAP));
endmodule

// File: rtl/wbc_credit_ctr.sv
module wbc_credit_ctr
   import wbc_pkg::*;
#(
   parameter int unsigned CAP   = 6,
   parameter int unsigned CNT_W = 3,
   parameter int unsigned INC_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INC_W-1:0]   ninc,
   input  logic [NUM_SRC-1:0] ret_vld,
   output logic [CNT_W-1:0]   count,
   output logic               issue_en,
   output logic               underflow_err
);
   localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);

   logic [CNT_W-1:0] count_q, count_nxt;
   logic             en_q, en_nxt;
   logic             uf_q, uf_now;
   int               ndec;
   int               net;

   always_comb begin
      ndec   = int'(ones_src(ret_vld));
      net    = int'(count_q) + int'(ninc) - ndec;
      uf_now = 1'b0;
      if (net < 0) begin
         uf_now = 1'b1;
         net    = 0;
      end
      count_nxt = CNT_W'(net);
      en_nxt    = (net < int'(CAP));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         en_q    <= 1'b1;
         uf_q    <= 1'b0;
      end else begin
         count_q <= count_nxt;
         en_q    <= en_nxt;
         uf_q    <= uf_q | uf_now;
      end
   end

   assign count         = count_q;
   assign issue_en      = en_q;
   assign underflow_err = uf_q;

   // R2: the count stays within capacity
   a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CAP_C);

   // R2: the enable register agrees with the count register
   a_r2_en_match: assert property (@(posedge clk) disable iff (!rst_n)
      en_q == (count_q < CAP_C));

   // R4: a return taken from a full count re-enables issue
   a_r4_reenable: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CAP_C && ret_vld != '0 && ninc == '0) |=> en_q);

   // R5: balanced grants and returns hold the count
   a_r5_net_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ninc) == int'(ones_src(ret_vld))) |=> $stable(count_q));

   // R6: a return at zero clamps and flags
   a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0 && ninc == '0 && ret_vld != '0) |=> (count_q == '0 && uf_q));

   // R6: the underflow flag is sticky
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      uf_q |=> uf_q);
endmodule

// File: rtl/wbc_slot_alloc.sv
module wbc_slot_alloc #(
   parameter int unsigned WB_WIDTH = 2,
   parameter int unsigned WB_DEPTH = 3,
   parameter int unsigned PORTS    = 4,
   parameter int unsigned CYC_W    = 2,
   parameter int unsigned LANE_W   = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PORTS-1:0]              req,
   output logic [PORTS-1:0]              ok,
   output logic [PORTS-1:0][CYC_W-1:0]   cyc,
   output logic [PORTS-1:0][LANE_W-1:0]  lane,
   output logic                          err
);
   localparam int unsigned CAP = WB_WIDTH * WB_DEPTH;

   logic [CAP-1:0] occ_q, occ_nxt, taken;
   logic           err_q, miss_now;
   logic           found;

   // Scan lanes of a cycle slot, wrap the lane and step to the next slot.
   always_comb begin
      taken    = occ_q;
      ok       = '0;
      cyc      = '0;
      lane     = '0;
      miss_now = 1'b0;
      found    = 1'b0;
      for (int p = 0; p < PORTS; p++) begin
         found = 1'b0;
         if (req[p]) begin
            for (int c = 0; c < WB_DEPTH; c++) begin
               for (int l = 0; l < WB_WIDTH; l++) begin
                  if (!found && !taken[c*WB_WIDTH + l]) begin
                     found                  = 1'b1;
                     taken[c*WB_WIDTH + l]  = 1'b1;
                     cyc[p]                 = CYC_W'(c);
                     lane[p]                = LANE_W'(l);
                  end
               end
            end
            ok[p] = found;
            if (!found) miss_now = 1'b1;
         end
      end
      occ_nxt = taken >> WB_WIDTH;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
         err_q <= 1'b0;
      end else begin
         occ_q <= occ_nxt;
         err_q <= err_q | miss_now;
      end
   end

   assign err = err_q;

   for (genvar p = 0; p < PORTS; p++) begin : g_port_chk
      // R7: a granted position lies below capacity
      a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
         ok[p] |-> (int'(cyc[p]) * WB_WIDTH + int'(lane[p])) < CAP);
      // R8: a granted position was free in the shifted map
      a_r8_was_free: assert property (@(posedge clk) disable iff (!rst_n)
         ok[p] |-> !occ_q[int'(cyc[p]) * WB_WIDTH + int'(lane[p])]);
   end

   // R9: an unserved request sets the sticky error
   a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      ((req & ~ok) != '0) |=> err_q);

   // R9: the slot error is sticky
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/wbc_tag_track.sv
module wbc_tag_track
   import wbc_pkg::*;
#(
   parameter int unsigned CAP   = 6,
   parameter int unsigned PORTS = 2,
   parameter int unsigned SEQ_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PORTS-1:0]              ins_vld,
   input  logic [PORTS-1:0][SEQ_W-1:0]   ins_seq,
   input  logic [NUM_SRC-1:0]            ret_vld,
   input  logic [NUM_SRC-1:0][SEQ_W-1:0] ret_seq,
   output logic                          tag_err
);
   logic [CAP-1:0]            valid_q, valid_nxt, clr, picked;
   logic [CAP-1:0][SEQ_W-1:0] seq_q, seq_nxt;
   logic [NUM_SRC-1:0]        hit;
   logic                      miss_now, dup, done;
   logic                      err_q;

   always_comb begin
      hit = '0;
      clr = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         for (int e = 0; e < CAP; e++) begin
            if (ret_vld[s] && valid_q[e] && seq_q[e] == ret_seq[s]) begin
               hit[s] = 1'b1;
               clr[e] = 1'b1;
            end
         end
      end
      miss_now = |(ret_vld & ~hit);
   end

   always_comb begin
      picked  = '0;
      seq_nxt = seq_q;
      done    = 1'b0;
      for (int p = 0; p < PORTS; p++) begin
         done = 1'b0;
         for (int e = 0; e < CAP; e++) begin
            if (ins_vld[p] && !done && !valid_q[e] && !picked[e]) begin
               done       = 1'b1;
               picked[e]  = 1'b1;
               seq_nxt[e] = ins_seq[p];
            end
         end
      end
      valid_nxt = (valid_q & ~clr) | picked;
   end

   // Input assumption: a granted issue reuses no outstanding number.
   always_comb begin
      dup = 1'b0;
      for (int p = 0; p < PORTS; p++) begin
         for (int e = 0; e < CAP; e++)
            if (ins_vld[p] && valid_q[e] && seq_q[e] == ins_seq[p]) dup = 1'b1;
         for (int q = p + 1; q < PORTS; q++)
            if (ins_vld[p] && ins_vld[q] && ins_seq[p] == ins_seq[q]) dup = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         err_q   <= 1'b0;
      end else begin
         valid_q <= valid_nxt;
         err_q   <= err_q | miss_now;
      end
   end

   always_ff @(posedge clk) seq_q <= seq_nxt;

   assign tag_err = err_q;

   // R10: issue numbers are fresh
   a_r10_fresh_issue: assert property (@(posedge clk) disable iff (!rst_n)
      !dup);

   // R4: return paths name distinct instructions in one cycle
   a_r4_distinct_returns: assert property (@(posedge clk) disable iff (!rst_n)
      !((ret_vld[SRC_WB] && ret_vld[SRC_EXE] && ret_seq[SRC_WB] == ret_seq[SRC_EXE]) ||
        (ret_vld[SRC_WB] && ret_vld[SRC_MEM] && ret_seq[SRC_WB] == ret_seq[SRC_MEM]) ||
        (ret_vld[SRC_EXE] && ret_vld[SRC_MEM] && ret_seq[SRC_EXE] == ret_seq[SRC_MEM])));

   // R10: an unknown return sets the sticky flag
   a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      miss_now |=> err_q);
endmodule

// File: rtl/wb_credit_throttle.sv
module wb_credit_throttle
   import wbc_pkg::*;
#(
   parameter int unsigned WB_WIDTH    = 2,
   parameter int unsigned WB_DEPTH    = 3,
   parameter int unsigned ISSUE_PORTS = 2,
   parameter int unsigned FIN_PORTS   = 4,
   parameter int unsigned SEQ_W       = 8,
   parameter bit          TRACK_TAGS  = 1'b1,
   localparam int unsigned CAP    = WB_WIDTH * WB_DEPTH,
   localparam int unsigned CNT_W  = $clog2(CAP + 1),
   localparam int unsigned CYC_W  = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1,
   localparam int unsigned LANE_W = (WB_WIDTH > 1) ? $clog2(WB_WIDTH) : 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [ISSUE_PORTS-1:0]             issue_req,
   input  logic [ISSUE_PORTS-1:0][SEQ_W-1:0]  issue_seq,
   output logic [ISSUE_PORTS-1:0]             issue_gnt,
   input  logic                               wb_done,
   input  logic [SEQ_W-1:0]                   wb_seq,
   input  logic                               exe_squash,
   input  logic [SEQ_W-1:0]                   exe_seq,
   input  logic                               mem_squash,
   input  logic [SEQ_W-1:0]                   mem_seq,
   input  logic [FIN_PORTS-1:0]               fin_req,
   output logic [FIN_PORTS-1:0]               fin_ok,
   output logic [FIN_PORTS-1:0][CYC_W-1:0]    fin_cycle,
   output logic [FIN_PORTS-1:0][LANE_W-1:0]   fin_lane,
   output logic                               issue_en,
   output logic [CNT_W-1:0]                   outstanding,
   output logic                               underflow_err,
   output logic                               slot_err,
   output logic                               tag_err
);
   localparam int unsigned INC_W = $clog2(ISSUE_PORTS + 1);

   initial begin
      a_cfg_width: assert (WB_WIDTH >= 1) else $fatal(1, "WB_WIDTH must be at least 1");
      a_cfg_depth: assert (WB_DEPTH >= 1) else $fatal(1, "WB_DEPTH must be at least 1");
      a_cfg_ports: assert (ISSUE_PORTS >= 1 && FIN_PORTS >= 1) else $fatal(1, "port counts must be at least 1");
      a_cfg_seq:   assert (SEQ_W >= 1) else $fatal(1, "SEQ_W must be at least 1");
   end

   logic [NUM_SRC-1:0]            ret_vld;
   logic [NUM_SRC-1:0][SEQ_W-1:0] ret_seq;
   logic [INC_W-1:0]              ninc;
   logic [CNT_W-1:0]              count;

   always_comb begin
      ret_vld          = '0;
      ret_seq          = '0;
      ret_vld[SRC_WB]  = wb_done;
      ret_seq[SRC_WB]  = wb_seq;
      ret_vld[SRC_EXE] = exe_squash;
      ret_seq[SRC_EXE] = exe_seq;
      ret_vld[SRC_MEM] = mem_squash;
      ret_seq[SRC_MEM] = mem_seq;
   end

   wbc_issue_gate #(
      .PORTS (ISSUE_PORTS),
      .CAP   (CAP),
      .CNT_W (CNT_W),
      .INC_W (INC_W)
   ) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .count (count),
      .req   (issue_req),
      .gnt   (issue_gnt),
      .ninc  (ninc)
   );

   wbc_credit_ctr #(
      .CAP   (CAP),
      .CNT_W (CNT_W),
      .INC_W (INC_W)
   ) u_ctr (
      .clk           (clk),
      .rst_n         (rst_n),
      .ninc          (ninc),
      .ret_vld       (ret_vld),
      .count         (count),
      .issue_en      (issue_en),
      .underflow_err (underflow_err)
   );

   wbc_slot_alloc #(
      .WB_WIDTH (WB_WIDTH),
      .WB_DEPTH (WB_DEPTH),
      .PORTS    (FIN_PORTS),
      .CYC_W    (CYC_W),
      .LANE_W   (LANE_W)
   ) u_slots (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (fin_req),
      .ok    (fin_ok),
      .cyc   (fin_cycle),
      .lane  (fin_lane),
      .err   (slot_err)
   );

   if (TRACK_TAGS) begin : g_tags
      wbc_tag_track #(
         .CAP   (CAP),
         .PORTS (ISSUE_PORTS),
         .SEQ_W (SEQ_W)
      ) u_tags (
         .clk     (clk),
         .rst_n   (rst_n),
         .ins_vld (issue_gnt),
         .ins_seq (issue_seq),
         .ret_vld (ret_vld),
         .ret_seq (ret_seq),
         .tag_err (tag_err)
      );
   end else begin : g_no_tags
      assign tag_err = 1'b0;
   end

   assign outstanding = count;
endmodule

// File: tb/test_wb_credit_throttle.sv
`timescale 1ns/1ps
module test_wb_credit_throttle;
   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       issue_req = '0;
   logic [1:0][7:0]  issue_seq = '0;
   logic [1:0]       issue_gnt;
   logic             wb_done = 1'b0, exe_squash = 1'b0, mem_squash = 1'b0;
   logic [7:0]       wb_seq = '0, exe_seq = '0, mem_seq = '0;
   logic [3:0]       fin_req = '0;
   logic [3:0]       fin_ok;
   logic [3:0][1:0]  fin_cycle;
   logic [3:0][0:0]  fin_lane;
   logic             issue_en;
   logic [2:0]       outstanding;
   logic             underflow_err, slot_err, tag_err;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   wb_credit_throttle i_wb_credit_throttle (
      .clk(clk), .rst_n(rst_n),
      .issue_req(issue_req), .issue_seq(issue_seq), .issue_gnt(issue_gnt),
      .wb_done(wb_done), .wb_seq(wb_seq),
      .exe_squash(exe_squash), .exe_seq(exe_seq),
      .mem_squash(mem_squash), .mem_seq(mem_seq),
      .fin_req(fin_req), .fin_ok(fin_ok), .fin_cycle(fin_cycle), .fin_lane(fin_lane),
      .issue_en(issue_en), .outstanding(outstanding),
      .underflow_err(underflow_err), .slot_err(slot_err), .tag_err(tag_err)
   );

   task automatic chk(input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic chk_slot(input string what, input int p, input int c, input int l);
      chk({what, " ok"}, int'(fin_ok[p]), 1);
      chk({what, " cycle"}, int'(fin_cycle[p]), c);
      chk({what, " lane"}, int'(fin_lane[p]), l);
   endtask

   task automatic quiet();
      issue_req  = '0;
      wb_done    = 1'b0;
      exe_squash = 1'b0;
      mem_squash = 1'b0;
      fin_req    = '0;
   endtask

   task automatic t_reset();
      chk("R1 count", int'(outstanding), 0);
      chk("R1 issue_en", int'(issue_en), 1);
      chk("R1 errors", int'({underflow_err, slot_err, tag_err}), 0);
   endtask

   task automatic t_credits();
      @(negedge clk); issue_req = 2'b11; issue_seq = {8'd2, 8'd1};
      #1 chk("R3 both granted", int'(issue_gnt), 3);
      @(negedge clk); chk("R4 count after two", int'(outstanding), 2);
      issue_seq = {8'd4, 8'd3};
      @(negedge clk); chk("R4 count after four", int'(outstanding), 4);
      issue_seq = {8'd6, 8'd5};
      @(negedge clk);
      chk("R2 count at capacity", int'(outstanding), 6);
      chk("R2 issue_en low when full", int'(issue_en), 0);
      issue_seq = {8'd8, 8'd7};
      #1 chk("R3 full denies all", int'(issue_gnt), 0);
      @(negedge clk);
      chk("R3 denied issue leaves count", int'(outstanding), 6);
      issue_req = '0; wb_done = 1'b1; wb_seq = 8'd1;
      @(negedge clk);
      chk("R4 writeback returns credit", int'(outstanding), 5);
      chk("R4 issue re-enabled", int'(issue_en), 1);
      wb_done = 1'b0; issue_req = 2'b11; issue_seq = {8'd8, 8'd7};
      #1 chk("R3 last credit to port 0 only", int'(issue_gnt), 1);
      @(negedge clk);
      chk("R2 full again", int'(issue_en), 0);
      issue_req = '0;
      wb_done = 1'b1; wb_seq = 8'd2;
      exe_squash = 1'b1; exe_seq = 8'd3;
      mem_squash = 1'b1; mem_seq = 8'd4;
      @(negedge clk);
      chk("R4 three return paths", int'(outstanding), 3);
      exe_squash = 1'b0; mem_squash = 1'b0;
      wb_seq = 8'd5; issue_req = 2'b11; issue_seq = {8'd10, 8'd9};
      @(negedge clk);
      chk("R5 two in one out", int'(outstanding), 4);
      wb_done = 1'b0; exe_squash = 1'b1; exe_seq = 8'd6;
      issue_req = 2'b01; issue_seq = {8'd0, 8'd11};
      @(negedge clk);
      chk("R5 balanced cycle holds count", int'(outstanding), 4);
      issue_req = '0; exe_squash = 1'b0;
      wb_done = 1'b1; wb_seq = 8'd7;
      exe_squash = 1'b1; exe_seq = 8'd9;
      mem_squash = 1'b1; mem_seq = 8'd10;
      @(negedge clk);
      chk("R4 drain to one", int'(outstanding), 1);
      exe_squash = 1'b0; mem_squash = 1'b0; wb_seq = 8'd11;
      @(negedge clk);
      quiet();
      chk("R4 drained", int'(outstanding), 0);
      chk("R10 matching returns leave tag_err clear", int'(tag_err), 0);
      chk("R6 no underflow on legal traffic", int'(underflow_err), 0);
   endtask

   task automatic t_slots();
      @(negedge clk); fin_req = 4'b0001;
      #1 chk_slot("R1 empty map first slot", 0, 0, 0);
      @(negedge clk); fin_req = 4'b1111;
      #1;
      chk_slot("R7 p0", 0, 0, 0);
      chk_slot("R7 p1", 1, 0, 1);
      chk_slot("R7 p2 wraps lane", 2, 1, 0);
      chk_slot("R7 p3", 3, 1, 1);
      @(negedge clk);
      #1;
      chk_slot("R8 shifted p0", 0, 1, 0);
      chk_slot("R8 shifted p1", 1, 1, 1);
      chk_slot("R8 shifted p2", 2, 2, 0);
      chk_slot("R8 shifted p3", 3, 2, 1);
      @(negedge clk);
      #1;
      chk_slot("R9 last p0", 0, 2, 0);
      chk_slot("R9 last p1", 1, 2, 1);
      chk("R9 full map denies", int'(fin_ok[3:2]), 0);
      chk("R9 flag not yet set", int'(slot_err), 0);
      @(negedge clk);
      fin_req = '0;
      chk("R9 slot_err set", int'(slot_err), 1);
      repeat (3) @(negedge clk);
      fin_req = 4'b1010;
      #1;
      chk("R7 idle ports not granted", int'({fin_ok[2], fin_ok[0]}), 0);
      chk_slot("R7 port order p1", 1, 0, 0);
      chk_slot("R7 port order p3", 3, 0, 1);
      @(negedge clk);
      fin_req = '0;
      chk("R9 slot_err sticky", int'(slot_err), 1);
   endtask

   task automatic t_tags();
      @(negedge clk); issue_req = 2'b01; issue_seq = {8'd0, 8'd50};
      @(negedge clk); issue_req = '0;
      chk("R10 setup count", int'(outstanding), 1);
      exe_squash = 1'b1; exe_seq = 8'd51;
      @(negedge clk); exe_squash = 1'b0;
      chk("R10 unknown number flags", int'(tag_err), 1);
      chk("R10 count still returned", int'(outstanding), 0);
   endtask

   task automatic t_underflow();
      @(negedge clk); wb_done = 1'b1; wb_seq = 8'd50;
      @(negedge clk); wb_done = 1'b0;
      chk("R6 count clamps at zero", int'(outstanding), 0);
      chk("R6 underflow flagged", int'(underflow_err), 1);
      chk("R2 issue_en high at zero", int'(issue_en), 1);
      @(negedge clk);
      chk("R6 underflow sticky", int'(underflow_err), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_credits();
      t_slots();
      t_tags();
      t_underflow();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule